// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block is the control section of a microcoded processor. A 512-entry control store holds 36-bit microinstructions. On every falling clock edge, a microinstruction register captures the word addressed by the microprogram counter. Its operation fields drive the data path directly: the ALU and shifter controls, the register write enables on the result bus, the memory operation and the operand-bus source select.

No counter increments the microprogram counter. Each word names its own successor. The next address is formed combinationally from four inputs: the successor field, three jump-control bits, the ALU sign and zero flags saved at the rising edge, and the instruction opcode byte presented by the fetch unit. A conditional branch does not need two targets. Its two outcomes differ only in address bit 8, which the taken condition forces high. A multiway dispatch ORs the opcode byte into the low eight bits, so the microcode for each opcode starts at the address equal to that opcode.

A loader port writes the control store one word per rising edge. The bench uses this port to set up microcode.

Top module: `useq_sequencer`

## Requirements
- R1: While reset is high, the register captures an all-zero word at each falling edge and the saved flags clear at each rising edge. As a result, the counter reads 0x000 and every control field output is zero.
- R2: At each falling edge with reset low, the register takes the control store word at the current counter value. The word is laid out from bit 35 down as: successor [35:27], dispatch bit [26], sign-test bit [25], zero-test bit [24], ALU/shifter [23:16], write enables [15:7], memory operation [6:4] (write, read, fetch), source select [3:0].
- R3: When all three jump-control bits are zero, the counter equals the successor field exactly.
- R4: Counter bit 8 is (zero-test AND saved Z) OR (sign-test AND saved N) OR successor bit 8. For example, successor 0x092 with a taken zero test gives 0x192.
- R5: When the dispatch bit is set, counter bits [7:0] are successor [7:0] OR the opcode byte. When it is clear, they are successor [7:0]. A dispatch from successor 0x000 on opcode 0x10 gives 0x010.
- R6: The sign and zero flags used in R4 are the values captured at the most recent rising edge. Changes on the flag inputs after that edge do not affect the counter.
- R7: No sequential increment exists. A chain of words is followed purely through the successor fields and the jump rules.
- R8: With the load enable high, a rising edge writes the load word into the control store at the load address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge, microinstruction register on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Control store write enable |
| ld_addr | input | 9 | Control store write address |
| ld_word | input | 36 | Control store write data |
| alu_n | input | 1 | ALU sign result from the data path |
| alu_z | input | 1 | ALU zero result from the data path |
| opcode | input | 8 | Opcode byte from the instruction fetch register |
| mpc | output | 9 | Current microprogram counter |
| alu_ctl | output | 8 | ALU and shifter controls |
| c_wen | output | 9 | Result-bus register write enables |
| mem_op | output | 3 | Memory operation: bit 2 write, bit 1 read, bit 0 fetch |
| b_sel | output | 4 | Operand-bus source select code |

## Verification
The bench builds the block with its default widths: a 9-bit counter, an 8-bit opcode and a 36-bit word. A single control store word can therefore cover every combination of the three jump bits and both flags. The bench crosses those 32 cases with 16 successor values, which reach both halves of the store, and 8 opcode bytes. For each of the 4096 vectors it checks the counter both before and after the flags are captured, which exposes any use of the live flag inputs. A four-word chain through a plain jump, a conditional branch, a dispatch and a sign-tested jump then checks that the words link in sequence.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int UA_W   = 9;
    localparam int OPC_W  = UA_W - 1;
    localparam int JAM_W  = 3;
    localparam int ALU_W  = 8;
    localparam int C_W    = 9;
    localparam int MEM_W  = 3;
    localparam int B_W    = 4;
    localparam int UI_W   = UA_W + JAM_W + ALU_W + C_W + MEM_W + B_W;
    localparam int DEPTH  = 1 << UA_W;

    typedef struct packed {
        logic jmpc;
        logic jamn;
        logic jamz;
    } jam_t;

    typedef struct packed {
        logic wr;
        logic rd;
        logic fetch;
    } memop_t;

    typedef struct packed {
        logic [UA_W-1:0]  succ;
        jam_t             jam;
        logic [ALU_W-1:0] alu;
        logic [C_W-1:0]   cwr;
        memop_t           mem;
        logic [B_W-1:0]   bsel;
    } uinstr_t;

    // Successor selection: high bit forced by a taken test, low bits merged with opcode on dispatch.
    function automatic logic [UA_W-1:0] pick_next(uinstr_t ui, logic n, logic z,
                                                  logic [OPC_W-1:0] opc);
        logic [UA_W-1:0] r;
        r[UA_W-1]    = ui.succ[UA_W-1] | (ui.jam.jamz & z) | (ui.jam.jamn & n);
        r[OPC_W-1:0] = ui.jam.jmpc ? (ui.succ[OPC_W-1:0] | opc) : ui.succ[OPC_W-1:0];
        return r;
    endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  logic            clk,
    input  logic            wr_en,
    input  logic [UA_W-1:0] wr_addr,
    input  logic [UI_W-1:0] wr_data,
    input  logic [UA_W-1:0] rd_addr,
    output logic [UI_W-1:0] rd_data
);
    logic [UI_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/useq_mir.sv
module useq_mir
    import useq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [UI_W-1:0] word_in,
    output uinstr_t         mir
);
    always_ff @(negedge clk) begin
        if (rst) mir <= '0;
        else     mir <= uinstr_t'(word_in);
    end

    // R1: reset at a falling edge leaves a null word for the next cycle
    a_r1_mir_clear: assert property (@(negedge clk) rst |=> (mir == '0));
endmodule

// File: rtl/useq_flags.sv
module useq_flags (
    input  logic clk,
    input  logic rst,
    input  logic n_in,
    input  logic z_in,
    output logic n_q,
    output logic z_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            n_q <= 1'b0;
            z_q <= 1'b0;
        end else begin
            n_q <= n_in;
            z_q <= z_in;
        end
    end

    // R6: saved flags follow the inputs of the previous rising edge
    a_r6_flag_capture: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (n_q == $past(n_in) && z_q == $past(z_in)));
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [UA_W-1:0]  ld_addr,
    input  logic [UI_W-1:0]  ld_word,
    input  logic             alu_n,
    input  logic             alu_z,
    input  logic [OPC_W-1:0] opcode,
    output logic [UA_W-1:0]  mpc,
    output logic [ALU_W-1:0] alu_ctl,
    output logic [C_W-1:0]   c_wen,
    output logic [MEM_W-1:0] mem_op,
    output logic [B_W-1:0]   b_sel
);
    uinstr_t         mir;
    logic [UI_W-1:0] cs_word;
    logic            n_q, z_q;

    useq_store u_store (
        .clk     (clk),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_data (ld_word),
        .rd_addr (mpc),
        .rd_data (cs_word)
    );

    useq_mir u_mir (
        .clk     (clk),
        .rst     (rst),
        .word_in (cs_word),
        .mir     (mir)
    );

    useq_flags u_flags (
        .clk  (clk),
        .rst  (rst),
        .n_in (alu_n),
        .z_in (alu_z),
        .n_q  (n_q),
        .z_q  (z_q)
    );

    assign mpc     = pick_next(mir, n_q, z_q, opcode);
    assign alu_ctl = mir.alu;
    assign c_wen   = mir.cwr;
    assign mem_op  = mir.mem;
    assign b_sel   = mir.bsel;

    // R3: no jump bits means the successor passes through untouched
    a_r3_direct: assert property (@(posedge clk) disable iff (rst)
        (mir.jam == 3'b000) |-> (mpc == mir.succ));
    // R4: a taken zero test always lands in the upper half
    a_r4_force_high: assert property (@(posedge clk) disable iff (rst)
        (mir.jam.jamz && z_q) |-> mpc[UA_W-1]);
    // R5: a pure dispatch never alters the high bit
    a_r5_dispatch_high: assert property (@(posedge clk) disable iff (rst)
        (mir.jam == 3'b100) |-> (mpc[UA_W-1] == mir.succ[UA_W-1]));
    // R5: dispatch keeps every opcode bit set in the low byte
    a_r5_dispatch_cover: assert property (@(posedge clk) disable iff (rst)
        mir.jam.jmpc |-> ((mpc[OPC_W-1:0] & opcode) == opcode));
endmodule

// File: tb/sim_useq_sequencer.sv
`timescale 1ns/1ps
module sim_useq_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [8:0]  ld_addr = '0;
    logic [35:0] ld_word = '0;
    logic        alu_n = 1'b0;
    logic        alu_z = 1'b0;
    logic [7:0]  opcode = '0;
    logic [8:0]  mpc;
    logic [7:0]  alu_ctl;
    logic [8:0]  c_wen;
    logic [2:0]  mem_op;
    logic [3:0]  b_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    useq_sequencer u0 (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_word(ld_word),
        .alu_n(alu_n), .alu_z(alu_z), .opcode(opcode), .mpc(mpc),
        .alu_ctl(alu_ctl), .c_wen(c_wen), .mem_op(mem_op), .b_sel(b_sel)
    );

    function automatic logic [8:0] expect_next(logic [35:0] w, logic n, logic z, logic [7:0] op);
        logic [8:0] s;
        logic [8:0] r;
        s = w[35:27];
        r[8] = s[8] | (w[24] & z) | (w[25] & n);
        r[7:0] = w[26] ? (s[7:0] | op) : s[7:0];
        return r;
    endfunction

    task automatic check(string req, logic [35:0] act, logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_fields(string req, logic [35:0] w);
        check(req, {27'd0, alu_ctl}, {27'd0, w[23:16]});
        check(req, {27'd0, c_wen},   {27'd0, w[15:7]});
        check(req, {33'd0, mem_op},  {33'd0, w[6:4]});
        check(req, {32'd0, b_sel},   {32'd0, w[3:0]});
    endtask

    // One word at address 0, run for a single cycle with chosen flags and opcode.
    task automatic apply(logic [35:0] w, logic n, logic z, logic [7:0] op);
        rst = 1'b1; ld_en = 1'b1; ld_addr = 9'h000; ld_word = w;
        @(posedge clk); #2;
        ld_en = 1'b0; rst = 1'b0;
        alu_n = n; alu_z = z; opcode = op;
        @(negedge clk); #5;
        check_fields("R2", w);
        check("R6", {27'd0, mpc}, {27'd0, expect_next(w, 1'b0, 1'b0, op)});
        @(posedge clk); #2;
        if (w[26:24] == 3'b000) check("R3", {27'd0, mpc}, {27'd0, w[35:27]});
        else if (w[26])         check("R5", {27'd0, mpc}, {27'd0, expect_next(w, n, z, op)});
        else                    check("R4", {27'd0, mpc}, {27'd0, expect_next(w, n, z, op)});
        rst = 1'b1;
    endtask

    task automatic load(logic [8:0] a, logic [35:0] w);
        ld_en = 1'b1; ld_addr = a; ld_word = w;
        @(posedge clk); #2;
        ld_en = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [35:0] w;
        logic [8:0]  sa;
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check("R1", {27'd0, mpc}, 36'd0);
        check_fields("R1", 36'd0);

        // Sweep of jump bits, flags, successor values and opcodes (R3, R4, R5, R6, R8)
        for (int ai = 0; ai < 16; ai++) begin
            sa = 9'((ai * 83) & 9'h1FF);
            for (int j = 0; j < 8; j++) begin
                for (int mi = 0; mi < 8; mi++) begin
                    for (int f = 0; f < 4; f++) begin
                        w = {sa, 3'(j), sa[7:0] ^ 8'h5A, 9'(ai * 29 + mi),
                             3'(mi), 4'(ai + j)};
                        apply(w, f[1], f[0], 8'((mi * 37) & 8'hFF));
                    end
                end
            end
        end

        // R1: the reset between vectors clears outputs again
        @(posedge clk); #2;
        @(negedge clk); #5;
        check("R1", {27'd0, mpc}, 36'd0);
        check_fields("R1", 36'd0);

        // R7 / R8: a linked chain with no increment
        rst = 1'b1;
        load(9'h000, {9'h005, 3'b000, 8'h11, 9'h001, 3'b010, 4'h1});
        load(9'h005, {9'h092, 3'b001, 8'h22, 9'h002, 3'b000, 4'h2});
        load(9'h192, {9'h000, 3'b100, 8'h33, 9'h004, 3'b001, 4'h3});
        load(9'h010, {9'h0A0, 3'b010, 8'h44, 9'h008, 3'b100, 4'h4});
        alu_n = 1'b0; alu_z = 1'b1; opcode = 8'h10;
        rst = 1'b0;
        @(negedge clk); #5;
        check("R7", {27'd0, mpc}, {27'd0, 9'h005});
        @(negedge clk); #5;
        check("R7", {27'd0, mpc}, {27'd0, 9'h192});
        @(negedge clk); #5;
        check("R7", {27'd0, mpc}, {27'd0, 9'h010});
        @(negedge clk); #5;
        check("R7", {27'd0, mpc}, {27'd0, 9'h0A0});
        check_fields("R8", {9'h0A0, 3'b010, 8'h44, 9'h008, 3'b100, 4'h4});

        // R6: live sign input rising after the edge leaves the counter alone
        alu_n = 1'b1;
        #3;
        check("R6", {27'd0, mpc}, {27'd0, 9'h0A0});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule